// File: doc/BRIEF.md
# UART Register Front End with Receive Queue

This block is the software-visible side of a UART, reached over an APB slave port. It holds a control register, a status view and a data port. Received characters arrive one byte at a time on a byte-stream input and wait in a receive queue until software reads the data port. Writing the data port sends one character out on a byte-stream output. The bit-level serializer, baud generation, parity logic and flow-control pins sit outside this block. A neighbouring serializer or a test model attaches to the two byte streams.

The APB port follows a three-phase tracker. The phases are `PH_IDLE`, `PH_SETUP` and `PH_ACCESS`. `PH_IDLE` moves to `PH_SETUP` when `psel` is high and `penable` is low. `PH_SETUP` moves to `PH_ACCESS` when `psel` and `penable` are both high. This transition is the only cycle in which a register read or write takes effect. `PH_SETUP` falls back to `PH_IDLE` if `psel` drops. `PH_ACCESS` returns to `PH_SETUP` when a new transfer starts at once, and otherwise to `PH_IDLE`.

A single interrupt line gives a one-cycle pulse for each accepted receive byte and for each transmitted byte, when the matching enable bit is set.

Top module: `uart_fe_top`

## Requirements
- R1: After reset, the status register reads 0x0000_0006 and the control register reads 0. `irq` and `tx_valid` are low and the receive queue is empty.
- R2: Address map (`paddr` is a byte address). The data port answers at 0x00 and also at 0x03. Status is at 0x04. Control is at 0x08 and is read/write over all 32 bits. Reads of 0x0C, 0x10 and any other address return 0. Writes to those addresses change no register.
- R3: A byte presented with `rx_valid` while control bit 0 (receive enable) is 0 is discarded, and the queue is left unchanged.
- R4: With receive enable set, each `rx_valid` cycle stores `rx_data` when the queue has room. Status bit 0 (data ready) is 1 while the queue holds at least one byte. Data-port reads return the bytes in arrival order in `prdata[7:0]`, with the upper bits zero. Data ready clears when the last byte is read.
- R5: A data-port read with the queue empty returns 0 and does not change the queue.
- R6: Status bit 10 is 1 and `rx_ready` is low when the queue holds `RX_DEPTH` bytes. Status bit 8 is 1 when it holds at least `RX_DEPTH/2` bytes.
- R7: An enabled byte that arrives while the queue is full is dropped and sets status bit 4 (overrun). Overrun stays set until a status write with bit 4 = 1. A status write with bit 4 = 0 leaves it set.
- R8: A write to the data port with control bit 1 (transmit enable) set raises `tx_valid` for exactly one cycle, the cycle after the access, with `tx_data` equal to `pwdata[7:0]`. With bit 1 clear, no byte is sent.
- R9: `irq` pulses for one cycle, the cycle after an accepted receive byte when control bit 2 is 1, or after a transmitted byte when control bit 3 is 1. Otherwise it stays low.
- R10: `pready` is always 1 and `pslverr` is always 0. Each APB transfer performs exactly one register action. Status bits 1 and 2 always read 1. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | 5 | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Always high (no wait states) |
| pslverr | output | 1 | Always low |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Low when the receive queue is full |
| tx_valid | output | 1 | One-cycle strobe for a transmitted byte |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A corrupted queue pointer or count shows up at the first data-port read after it. The read returns a byte out of order or zero, or data ready reads wrong in the next status read. A phase tracker stuck in the wrong state either loses a register action or repeats one. The result is visible in the same transfer, as a missing byte on `tx_valid` or a double pop. A stuck overrun or enable bit shows in the next status read, in an `irq` pulse that is missing or unexpected, or in a transmit byte one cycle after the write. The bench runs a scoreboard of expected transmit bytes and a model of the receive queue.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_DATA    = 5'h00;
    localparam logic [ADDR_W-1:0] A_DATA_B3 = 5'h03;
    localparam logic [ADDR_W-1:0] A_STAT    = 5'h04;
    localparam logic [ADDR_W-1:0] A_CTRL    = 5'h08;

    localparam int SB_READY = 0;
    localparam int SB_TSE   = 1;
    localparam int SB_TFE   = 2;
    localparam int SB_OVR   = 4;
    localparam int SB_RHALF = 8;
    localparam int SB_RFULL = 10;

    localparam int CB_RXEN = 0;
    localparam int CB_TXEN = 1;
    localparam int CB_RXIE = 2;
    localparam int CB_TXIE = 3;

    typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACCESS} apb_phase_e;
endpackage

// File: rtl/uart_fe_apb_fsm.sv
module uart_fe_apb_fsm
    import uart_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic rd_stb,
    output logic wr_stb
);
    apb_phase_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (psel && !penable) state_d = PH_SETUP;
            PH_SETUP:  if (psel && penable)  state_d = PH_ACCESS;
                       else if (!psel)       state_d = PH_IDLE;
            PH_ACCESS: if (psel && !penable) state_d = PH_SETUP;
                       else                  state_d = PH_IDLE;
            default:   state_d = PH_IDLE;
        endcase
    end

    // Action strobes: one per SETUP -> ACCESS transition
    always_comb begin
        rd_stb = 1'b0;
        wr_stb = 1'b0;
        if (state_q == PH_SETUP && psel && penable) begin
            rd_stb = !pwrite;
            wr_stb = pwrite;
        end
    end
endmodule

// File: rtl/uart_fe_rx_fifo.sv
module uart_fe_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic             empty,
    output logic             full,
    output logic             half,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CAP);
    assign half    = (count >= HALF);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            if (do_push && !do_pop)      count <= count + CNT_W'(1);
            else if (do_pop && !do_push) count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/uart_fe_evt.sv
module uart_fe_evt (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_fire,
    input  logic [7:0] tx_byte,
    input  logic       rx_push,
    input  logic       rx_ie,
    input  logic       tx_ie,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
            irq      <= 1'b0;
        end else begin
            tx_valid <= tx_fire;
            if (tx_fire) tx_data <= tx_byte;
            irq <= (rx_push && rx_ie) || (tx_fire && tx_ie);
        end
    end
endmodule

// File: rtl/uart_fe_top.sv
module uart_fe_top
    import uart_fe_pkg::*;
#(
    parameter int RX_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [4:0]  paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        pready,
    output logic        pslverr,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        irq
);
    localparam int CNT_W = $clog2(RX_DEPTH+1);

    logic             rd_stb, wr_stb;
    logic [31:0]      ctrl_q;
    logic             ovr_q;
    logic [7:0]       q_head;
    logic             q_empty, q_full, q_half;
    logic [CNT_W-1:0] fifo_cnt;
    logic             is_data, pop_go, rx_take, push_go, drop_go, tx_fire;
    logic [31:0]      stat_v;

    uart_fe_apb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .rd_stb(rd_stb), .wr_stb(wr_stb)
    );

    assign is_data = (paddr == A_DATA) || (paddr == A_DATA_B3);
    assign pop_go  = rd_stb && is_data && !q_empty;
    assign rx_take = rx_valid && ctrl_q[CB_RXEN];
    assign push_go = rx_take && !q_full;
    assign drop_go = rx_take && q_full;
    assign tx_fire = wr_stb && is_data && ctrl_q[CB_TXEN];

    uart_fe_rx_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(push_go), .wdata(rx_data),
        .pop(pop_go), .rdata(q_head), .empty(q_empty), .full(q_full),
        .half(q_half), .count(fifo_cnt)
    );

    uart_fe_evt u_evt (
        .clk(clk), .rst_n(rst_n), .tx_fire(tx_fire), .tx_byte(pwdata[7:0]),
        .rx_push(push_go), .rx_ie(ctrl_q[CB_RXIE]), .tx_ie(ctrl_q[CB_TXIE]),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (wr_stb && paddr == A_CTRL) ctrl_q <= pwdata;
            if (drop_go)
                ovr_q <= 1'b1;
            else if (wr_stb && paddr == A_STAT && pwdata[SB_OVR])
                ovr_q <= 1'b0;
        end
    end

    always_comb begin
        stat_v           = '0;
        stat_v[SB_READY] = !q_empty;
        stat_v[SB_TSE]   = 1'b1;
        stat_v[SB_TFE]   = 1'b1;
        stat_v[SB_OVR]   = ovr_q;
        stat_v[SB_RHALF] = q_half;
        stat_v[SB_RFULL] = q_full;
    end

    always_comb begin
        prdata = '0;
        if (rd_stb) begin
            case (paddr)
                A_DATA, A_DATA_B3: prdata = q_empty ? 32'd0 : {24'd0, q_head};
                A_STAT:            prdata = stat_v;
                A_CTRL:            prdata = ctrl_q;
                default:           prdata = '0;
            endcase
        end
    end

    assign rx_ready = !q_full;
    assign pready   = 1'b1;
    assign pslverr  = 1'b0;
endmodule

// File: rtl/uart_fe_checker.sv
module uart_fe_checker #(
    parameter int RX_DEPTH = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         pready,
    input logic                         pslverr,
    input logic                         tx_valid,
    input logic                         irq,
    input logic [31:0]                  ctrl_q,
    input logic                         ovr_q,
    input logic [$clog2(RX_DEPTH+1)-1:0] fifo_cnt,
    input logic                         pop_go,
    input logic                         wr_stb,
    input logic [4:0]                   paddr,
    input logic                         clr_bit
);
    localparam int CNT_W = $clog2(RX_DEPTH+1);

    p_apb_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(RX_DEPTH));

    // R3: with receive disabled the queue can only shrink
    p_rx_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[0] && !pop_go) |=> (fifo_cnt <= $past(fifo_cnt)));

    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !(wr_stb && paddr == 5'h04 && clr_bit)) |=> ovr_q);

    p_tx_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    p_tx_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(ctrl_q[1]));

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ctrl_q[2] || ctrl_q[3]));
endmodule

bind uart_fe_top uart_fe_checker #(.RX_DEPTH(RX_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .pready(pready), .pslverr(pslverr),
    .tx_valid(tx_valid), .irq(irq), .ctrl_q(ctrl_q), .ovr_q(ovr_q),
    .fifo_cnt(fifo_cnt), .pop_go(pop_go), .wr_stb(wr_stb),
    .paddr(paddr), .clr_bit(pwdata[4])
);

// File: tb/tb_uart_fe_top.sv
`timescale 1ns/1ps
module tb_uart_fe_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int checks = 0, fails = 0;
    logic [7:0]  exp_tx[$];
    logic [7:0]  rxq[$];
    logic [31:0] m_ctrl = '0;
    logic        m_ovr = 1'b0;
    logic        last_irq;
    logic [31:0] rd_val;

    always #2 clk = ~clk;

    uart_fe_top #(.RX_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        logic [31:0] s = 32'h6;
        s[0]  = (rxq.size() > 0);
        s[4]  = m_ovr;
        s[8]  = (rxq.size() >= DEPTH/2);
        s[10] = (rxq.size() == DEPTH);
        return s;
    endfunction

    // Scoreboard monitor for transmitted bytes
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (exp_tx.size() == 0) begin
                chk(1'b0, "R8 unexpected tx", {24'd0, tx_data}, 32'd0);
            end else begin
                logic [7:0] e;
                e = exp_tx.pop_front();
                chk(tx_data == e, "R8 tx byte", {24'd0, tx_data}, {24'd0, e});
            end
        end
    end

    task automatic apb_write(input logic [4:0] a, input logic [31:0] d);
        bit is_d = (a == 5'h00 || a == 5'h03);
        if (is_d && m_ctrl[1]) exp_tx.push_back(d[7:0]);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        chk(pready && !pslverr, "R10 write response", {30'd0, pslverr, pready}, 32'd1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        last_irq = irq;
        if (a == 5'h08) m_ctrl = d;
        if (a == 5'h04 && d[4]) m_ovr = 1'b0;
    endtask

    task automatic apb_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #0.5;
        d = prdata;
        chk(pready && !pslverr, "R10 read response", {30'd0, pslverr, pready}, 32'd1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        if (m_ctrl[0]) begin
            if (rxq.size() < DEPTH) rxq.push_back(b);
            else m_ovr = 1'b1;
        end
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
        last_irq = irq;
    endtask

    task automatic read_byte(input logic [4:0] a, input string req);
        logic [7:0] e;
        e = (rxq.size() > 0) ? rxq.pop_front() : 8'd0;
        apb_read(a, rd_val);
        chk(rd_val == {24'd0, e}, req, rd_val, {24'd0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!irq && !tx_valid, "R1 outputs idle", {30'd0, irq, tx_valid}, 32'd0);
        chk(rx_ready, "R1 queue empty", {31'd0, rx_ready}, 32'd1);
        apb_read(5'h04, rd_val); chk(rd_val == 32'h6, "R1 status", rd_val, 32'h6);
        apb_read(5'h08, rd_val); chk(rd_val == 32'h0, "R1 control", rd_val, 32'h0);
        // R5 empty read
        read_byte(5'h00, "R5 empty read");
        apb_read(5'h04, rd_val); chk(rd_val == exp_stat(), "R5 status unchanged", rd_val, exp_stat());
        // R3 receive disabled
        rx_push(8'h11);
        chk(!last_irq, "R3 no irq", {31'd0, last_irq}, 32'd0);
        apb_read(5'h04, rd_val); chk(rd_val == exp_stat(), "R3 status", rd_val, exp_stat());
        read_byte(5'h00, "R3 queue unchanged");
        // R2 control rw, R9 rx irq, R4 data ready
        apb_write(5'h08, 32'h8000_0005);
        apb_read(5'h08, rd_val); chk(rd_val == 32'h8000_0005, "R2 control rw", rd_val, 32'h8000_0005);
        rx_push(8'hA5);
        chk(last_irq, "R9 rx irq pulse", {31'd0, last_irq}, 32'd1);
        @(negedge clk);
        chk(!irq, "R9 pulse one cycle", {31'd0, irq}, 32'd0);
        apb_read(5'h04, rd_val); chk(rd_val == exp_stat(), "R4 data ready set", rd_val, exp_stat());
        read_byte(5'h03, "R2 data alias 0x03");
        apb_read(5'h04, rd_val); chk(rd_val == exp_stat(), "R4 data ready clear", rd_val, exp_stat());
        // R9 no irq without enable; R4 ordering
        apb_write(5'h08, 32'h1);
        rx_push(8'h01);
        chk(!last_irq, "R9 rx irq masked", {31'd0, last_irq}, 32'd0);
        rx_push(8'h02); rx_push(8'h03);
        read_byte(5'h00, "R4 order 1");
        read_byte(5'h03, "R4 order 2");
        read_byte(5'h00, "R4 order 3");
        // R6 fill, R7 overrun
        for (int i = 0; i < DEPTH; i++) begin
            rx_push(8'h40 + 8'(i));
            if (i == DEPTH/2 - 1) begin
                apb_read(5'h04, rd_val); chk(rd_val == exp_stat(), "R6 half flag", rd_val, exp_stat());
            end
        end
        chk(!rx_ready, "R6 rx_ready low when full", {31'd0, rx_ready}, 32'd0);
        apb_read(5'h04, rd_val); chk(rd_val == exp_stat(), "R6 full flag", rd_val, exp_stat());
        rx_push(8'hEE);
        apb_read(5'h04, rd_val); chk(rd_val == exp_stat(), "R7 overrun set", rd_val, exp_stat());
        apb_write(5'h04, 32'h0);
        apb_read(5'h04, rd_val); chk(rd_val[4], "R7 overrun sticky", rd_val, exp_stat());
        apb_write(5'h04, 32'h10);
        apb_read(5'h04, rd_val); chk(rd_val == exp_stat(), "R7 overrun cleared", rd_val, exp_stat());
        for (int i = 0; i < DEPTH; i++) read_byte(5'h00, "R4 drain order");
        chk(rx_ready, "R6 ready after drain", {31'd0, rx_ready}, 32'd1);
        // R8 transmit gating, R9 tx irq
        apb_write(5'h08, 32'h0);
        apb_write(5'h00, 32'h41);
        apb_write(5'h08, 32'h2);
        apb_write(5'h00, 32'h142);
        chk(!last_irq, "R9 tx irq masked", {31'd0, last_irq}, 32'd0);
        apb_write(5'h08, 32'hA);
        apb_write(5'h03, 32'h43);
        chk(last_irq, "R9 tx irq pulse", {31'd0, last_irq}, 32'd1);
        // R2 unsupported offsets
        apb_write(5'h0C, 32'hFFFF_FFFF);
        apb_write(5'h10, 32'hFFFF_FFFF);
        apb_read(5'h0C, rd_val); chk(rd_val == 32'h0, "R2 scaler reads zero", rd_val, 32'h0);
        apb_read(5'h10, rd_val); chk(rd_val == 32'h0, "R2 debug reads zero", rd_val, 32'h0);
        apb_read(5'h08, rd_val); chk(rd_val == 32'hA, "R2 ignored writes", rd_val, 32'hA);
        apb_read(5'h04, rd_val); chk(rd_val == 32'h6, "R10 fixed status bits", rd_val, 32'h6);
        repeat (3) @(negedge clk);
        chk(exp_tx.size() == 0, "R8 all bytes sent", exp_tx.size(), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule